// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a legacy I/O controller. The host sees it as a byte-wide I/O bus with two ports: an index port at the base address and a data port at the next address. Decoding of those two addresses happens above the block. It sees only a one-bit port select, `addr_i`, where 0 means the index port and 1 means the data port.

The configuration space starts out locked. While locked, every byte written to the index port goes to a key detector. Once the four-byte key has arrived, index-port writes choose a register and data-port accesses read or write it. A device-select register picks which logical device's register bank the data port reaches:

- The device at `GPIO_LDN` is a bank of numbered GPIO sets.
- The other devices each hold a small general-purpose register file.

Writing the exit command into the control register locks the space again. The index and the device select keep their values when this happens.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the block is locked (`unlocked_o`=0). The index, the device select and every bank register are 0x00.
- R2: The space unlocks only after the index port receives 0x87, 0x01, 0x55 and a last byte, all in order. The last byte is 0xAA when `BASE_PORT` is 0x4E and 0x55 when it is 0x2E. Any other last byte leaves the block locked.
- R3: While locked, a byte that does not match the expected key byte sends the detector back to expecting 0x87. The exception is a mismatching 0x87, which counts as the first key byte, so the detector next expects 0x01.
- R4: While locked, data-port writes change nothing and data-port reads return 0xFF. Index-port reads return 0xFF at all times.
- R5: While unlocked, an index-port write stores the register index. A data-port write or read then reaches the register selected by that index. `rdata_o` is 0x00 whenever `rd_en_i` is low.
- R6: Index 0x07 is the device select, a full byte that reads back as written. It chooses the bank for all later accesses. A value of `NDEV` or above selects no bank: reads return 0x00 and writes are dropped.
- R7: A general device holds `NREG` (default 16) bytes at indices 0x100-`NREG` through 0xFF. Its other indices read 0x00 and ignore writes.
- R8: The GPIO device decodes an index as 0b11 in bits 7:6, a kind in bits 5:3 and a set in bits 2:0. The kinds are 0 select, 1 enable, 2 polarity, 3 output and 4 pull-up. Only sets below `NFULL` (default 5) have kinds 0 to 2. Every set below `NSETS` has kinds 3 and 4. Missing registers read 0x00 and ignore writes.
- R9: Writing 0x02 to the control register at index 0x02 locks the block. Writing any other value there has no effect. The index, the device select and all bank contents survive the exit.
- R10: The control register at index 0x02 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, one byte per cycle |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 1 | Port select: 0 index port, 1 data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the current state |
| unlocked_o | output | 1 | High while configuration access is open |

## Verification
The assertions check four behaviours on every cycle:
- An unlock always follows a write of the last key byte.
- A stray 0x87 always restarts the detector at its second step.
- The exit command always locks, and it leaves the index and the device select unchanged.
- While locked, data reads return 0xFF and data writes leave the device select alone.

Only the bench scenarios can show the rest. These are the full key paths, including the wrong last byte on both base ports, where the GPIO bank has register holes, bank switching, and what survives a full lock/unlock round trip.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_LAST_4E = 8'hAA;
  localparam logic [7:0] KEY_LAST_2E = 8'h55;
  localparam logic [7:0] IDX_CTRL    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] EXIT_CMD    = 8'h02;
  localparam int unsigned GPIO_KINDS = 5;

  typedef enum logic [2:0] {
    LK_S0, LK_S1, LK_S2, LK_S3, LK_OPEN
  } lock_state_e;
endpackage

// File: rtl/cfg_key_detect.sv
module cfg_key_detect
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] BASE_PORT = 8'h4E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       open_o
);
  localparam logic [7:0] KEY_LAST = (BASE_PORT == 8'h4E) ? KEY_LAST_4E : KEY_LAST_2E;

  lock_state_e state_q, state_d;
  logic [7:0]  exp_b;
  lock_state_e adv;

  always_comb begin
    unique case (state_q)
      LK_S0:   begin exp_b = KEY_B0;   adv = LK_S1;   end
      LK_S1:   begin exp_b = KEY_B1;   adv = LK_S2;   end
      LK_S2:   begin exp_b = KEY_B2;   adv = LK_S3;   end
      LK_S3:   begin exp_b = KEY_LAST; adv = LK_OPEN; end
      default: begin exp_b = KEY_LAST; adv = LK_OPEN; end
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == LK_OPEN) begin
      if (exit_i) state_d = LK_S0;
    end else if (wr_i) begin
      if (wdata_i == exp_b)       state_d = adv;
      else if (wdata_i == KEY_B0) state_d = LK_S1;  // stray first byte restarts
      else                        state_d = LK_S0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_S0;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);

  p_open_after_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(wr_i && wdata_i == KEY_LAST));

  p_stray_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && wr_i && wdata_i == KEY_B0) |=> (state_q == LK_S1));

  p_exit_locks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && exit_i) |=> !open_o);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cfg_gpio_bank.sv
module cfg_gpio_bank #(
  parameter int unsigned NSETS = 8,
  parameter int unsigned NFULL = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] kind_i,
  input  logic [2:0] set_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] set_rd [NSETS];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic       hit;
    logic [7:0] out_q, pu_q;
    assign hit = we_i && (set_i == 3'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= 8'h00;
        pu_q  <= 8'h00;
      end else if (hit) begin
        if (kind_i == 3'd3) out_q <= wdata_i;
        if (kind_i == 3'd4) pu_q  <= wdata_i;
      end
    end

    if (s < NFULL) begin : g_full
      logic [7:0] sel_q, en_q, pol_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sel_q <= 8'h00;
          en_q  <= 8'h00;
          pol_q <= 8'h00;
        end else if (hit) begin
          if (kind_i == 3'd0) sel_q <= wdata_i;
          if (kind_i == 3'd1) en_q  <= wdata_i;
          if (kind_i == 3'd2) pol_q <= wdata_i;
        end
      end
      always_comb begin
        unique case (kind_i)
          3'd0:    set_rd[s] = sel_q;
          3'd1:    set_rd[s] = en_q;
          3'd2:    set_rd[s] = pol_q;
          3'd3:    set_rd[s] = out_q;
          3'd4:    set_rd[s] = pu_q;
          default: set_rd[s] = 8'h00;
        endcase
      end
    end else begin : g_part
      always_comb begin
        unique case (kind_i)
          3'd3:    set_rd[s] = out_q;
          3'd4:    set_rd[s] = pu_q;
          default: set_rd[s] = 8'h00;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int s = 0; s < NSETS; s++)
      if (set_i == 3'(s)) rdata_o = set_rd[s];
  end
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfg_port_pkg::*;
#(
  parameter logic [7:0]  BASE_PORT = 8'h4E,
  parameter int unsigned NDEV      = 4,
  parameter int unsigned GPIO_LDN  = 2,
  parameter int unsigned NREG      = 16,
  parameter int unsigned NSETS     = 8,
  parameter int unsigned NFULL     = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       unlocked_o
);
  localparam int unsigned AW       = $clog2(NREG);
  localparam logic [7:0]  GEN_BASE = 8'(256 - NREG);

  logic       open;
  logic       wr_idx, wr_dat, exit_cmd;
  logic [7:0] idx_q, ldn_q;
  logic       gen_hit, gpio_hit;
  logic [7:0] gen_off;
  logic [7:0] dev_rd [NDEV];

  assign wr_idx   = wr_en_i && !addr_i && open;
  assign wr_dat   = wr_en_i &&  addr_i && open;
  assign exit_cmd = wr_dat && (idx_q == IDX_CTRL) && (wdata_i == EXIT_CMD);

  cfg_key_detect #(.BASE_PORT(BASE_PORT)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i && !addr_i),
    .wdata_i(wdata_i),
    .exit_i (exit_cmd),
    .open_o (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (wr_idx) idx_q <= wdata_i;
      if (wr_dat && idx_q == IDX_LDN) ldn_q <= wdata_i;
    end
  end

  assign gen_hit  = (idx_q >= GEN_BASE);
  assign gen_off  = idx_q - GEN_BASE;
  assign gpio_hit = (idx_q[7:6] == 2'b11) && (idx_q[5:3] < 3'(GPIO_KINDS));

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic       sel;
    logic [7:0] raw;
    assign sel = (ldn_q == 8'(d));
    if (d == GPIO_LDN) begin : g_gpio
      cfg_gpio_bank #(.NSETS(NSETS), .NFULL(NFULL)) u_gpio (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_dat && sel && gpio_hit),
        .kind_i (idx_q[5:3]),
        .set_i  (idx_q[2:0]),
        .wdata_i(wdata_i),
        .rdata_o(raw)
      );
      assign dev_rd[d] = gpio_hit ? raw : 8'h00;
    end else begin : g_gen
      cfg_reg_bank #(.NREG(NREG)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_dat && sel && gen_hit),
        .addr_i (gen_off[AW-1:0]),
        .wdata_i(wdata_i),
        .rdata_o(raw)
      );
      assign dev_rd[d] = gen_hit ? raw : 8'h00;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_en_i) begin
      if (!addr_i || !open)      rdata_o = 8'hFF;
      else if (idx_q == IDX_LDN) rdata_o = ldn_q;
      else begin
        for (int d = 0; d < NDEV; d++)
          if (ldn_q == 8'(d)) rdata_o = dev_rd[d];
      end
    end
  end

  assign unlocked_o = open;

  p_locked_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && rd_en_i && addr_i) |-> (rdata_o == 8'hFF));

  p_locked_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && wr_en_i && addr_i) |=> $stable(ldn_q));

  p_exit_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_cmd |=> ($stable(idx_q) && $stable(ldn_q) && !unlocked_o));
endmodule

// File: tb/cfg_port_unlock_tb.sv
module cfg_port_unlock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic unlocked;
  logic wr2 = 1'b0, a2 = 1'b0, rd2 = 1'b0;
  logic [7:0] d2 = 8'h00;
  logic [7:0] rdata2;
  logic unlocked2;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model of the requirements (base port 0x4E)
  bit m_open = 1'b0;
  int m_st = 0;
  logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;
  logic [7:0] m_gen [4][16];
  logic [7:0] m_gpio [5][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_unlock #(.BASE_PORT(8'h4E)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .unlocked_o(unlocked));

  cfg_port_unlock #(.BASE_PORT(8'h2E)) u_dut_2e (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr2), .rd_en_i(rd2),
    .addr_i(a2), .wdata_i(d2), .rdata_o(rdata2), .unlocked_o(unlocked2));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic void mdl_key(input logic [7:0] d);
    logic [7:0] e;
    case (m_st)
      0: e = 8'h87;
      1: e = 8'h01;
      2: e = 8'h55;
      default: e = 8'hAA;
    endcase
    if (d == e) begin
      if (m_st == 3) begin m_open = 1'b1; m_st = 0; end
      else m_st++;
    end else m_st = (d == 8'h87) ? 1 : 0;
  endfunction

  function automatic bit gpio_ok(input logic [7:0] i);
    return (i[7:6] == 2'b11) && (i[5:3] <= 3'd4) && (i[5:3] >= 3'd3 || i[2:0] < 3'd5);
  endfunction

  function automatic void mdl_write(input logic a, input logic [7:0] d);
    if (!m_open) begin
      if (!a) mdl_key(d);
    end else if (!a) m_idx = d;
    else if (m_idx == 8'h02) begin
      if (d == 8'h02) begin m_open = 1'b0; m_st = 0; end
    end else if (m_idx == 8'h07) m_ldn = d;
    else if (m_ldn == 8'd2) begin
      if (gpio_ok(m_idx)) m_gpio[m_idx[5:3]][m_idx[2:0]] = d;
    end else if (m_ldn < 8'd4 && m_idx >= 8'hF0) m_gen[m_ldn][m_idx[3:0]] = d;
  endfunction

  function automatic logic [7:0] exp_read(input logic a);
    if (!a || !m_open) return 8'hFF;
    if (m_idx == 8'h07) return m_ldn;
    if (m_ldn == 8'd2) return gpio_ok(m_idx) ? m_gpio[m_idx[5:3]][m_idx[2:0]] : 8'h00;
    if (m_ldn < 8'd4 && m_idx >= 8'hF0) return m_gen[m_ldn][m_idx[3:0]];
    return 8'h00;
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic rd(input logic a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 chk(tag, rdata, exp_read(a));
    rd_en = 1'b0;
  endtask

  task automatic wr2e(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr2 = 1'b1; a2 = a; d2 = d;
    @(posedge clk);
    #1 wr2 = 1'b0;
  endtask

  task automatic unlock4e();
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'hAA);
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] d);
    wr(0, i); wr(1, d);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int d = 0; d < 4; d++) for (int r = 0; r < 16; r++) m_gen[d][r] = 8'h00;
    for (int k = 0; k < 5; k++) for (int s = 0; s < 8; s++) m_gpio[k][s] = 8'h00;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state, R4 locked reads
    @(negedge clk);
    chk("R1 unlocked after reset", {7'd0, unlocked}, 8'h00);
    rd(1, "R4 locked data read");
    rd(0, "R4 index port read");

    // R2 wrong last byte for 0x4E base
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    chk("R2 wrong last byte 4E", {7'd0, unlocked}, 8'h00);
    // R3 broken sequence then no unlock from mid-key bytes
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h12); wr(0, 8'h55); wr(0, 8'hAA);
    chk("R3 break resets detector", {7'd0, unlocked}, 8'h00);
    // R3 stray 0x87 restarts at step two
    wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'hAA);
    chk("R3 stray 87 restart", {7'd0, unlocked}, 8'h01);

    // R1 fresh register contents, R5 readback
    wr(0, 8'hF3); rd(1, "R1 reset bank value");
    wr(1, 8'h3C); rd(1, "R5 readback F3");
    set_reg(8'hFF, 8'hA5); rd(1, "R5 readback FF");
    wr(0, 8'h40); rd(1, "R7 outside general window");
    wr(1, 8'h77); rd(1, "R7 write outside window dropped");
    wr(0, 8'h02); rd(1, "R10 control reads zero");

    // R6 bank switching
    set_reg(8'h07, 8'h01); rd(1, "R6 ldn readback");
    wr(0, 8'hF3); rd(1, "R6 bank1 separate");
    wr(1, 8'h5E); rd(1, "R6 bank1 write");
    set_reg(8'h07, 8'h00); wr(0, 8'hF3); rd(1, "R6 bank0 kept");
    set_reg(8'h07, 8'h09); wr(0, 8'hF3); wr(1, 8'hEE); rd(1, "R6 out of range bank");
    set_reg(8'h07, 8'h00); wr(0, 8'hF3); rd(1, "R6 out of range write dropped");

    // R8 GPIO bank
    set_reg(8'h07, 8'h02);
    set_reg(8'hC4, 8'h11); rd(1, "R8 select set4");
    set_reg(8'hC5, 8'h22); rd(1, "R8 select set5 absent");
    set_reg(8'hD5, 8'h33); rd(1, "R8 polarity set5 absent");
    set_reg(8'hDD, 8'h44); rd(1, "R8 output set5");
    set_reg(8'hE7, 8'h55); rd(1, "R8 pullup set7");
    set_reg(8'hE8, 8'h66); rd(1, "R8 kind5 absent");
    set_reg(8'hF2, 8'h67); rd(1, "R8 general index in gpio bank");

    // R9 exit
    wr(0, 8'h02); wr(1, 8'h03);
    chk("R9 other ctrl value", {7'd0, unlocked}, 8'h01);
    wr(1, 8'h02);
    chk("R9 exit locks", {7'd0, unlocked}, 8'h00);
    rd(1, "R4 data read after exit");
    wr(1, 8'h99);  // R4 ignored while locked
    wr(0, 8'hDD);  // key detector byte, not an index
    unlock4e();
    chk("R2 relock unlock", {7'd0, unlocked}, 8'h01);
    rd(1, "R9 index kept at control");
    wr(0, 8'h07); rd(1, "R9 ldn kept");
    wr(0, 8'hDD); rd(1, "R9 gpio contents kept");

    // R2 base 0x2E: 0xAA fails, 0x55 works, then exit
    wr2e(0, 8'h87); wr2e(0, 8'h01); wr2e(0, 8'h55); wr2e(0, 8'hAA);
    chk("R2 wrong last byte 2E", {7'd0, unlocked2}, 8'h00);
    wr2e(0, 8'h87); wr2e(0, 8'h01); wr2e(0, 8'h55); wr2e(0, 8'h55);
    chk("R2 unlock 2E", {7'd0, unlocked2}, 8'h01);
    wr2e(0, 8'h02); wr2e(1, 8'h02);
    chk("R9 exit 2E", {7'd0, unlocked2}, 8'h00);

    // constrained random phase against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom % 10;
      case (op)
        0, 1: begin
          case ($urandom % 5)
            0: v = 8'h07;
            1: v = 8'hF0 | 8'($urandom % 16);
            2: v = 8'hC0 + 8'($urandom % 40);
            3: v = 8'h02;
            default: v = 8'($urandom);
          endcase
          wr(0, v);
        end
        2, 3, 4: begin
          v = 8'($urandom);
          if (m_idx == 8'h07) v = 8'($urandom % 6);
          if (m_idx == 8'h02 && v == 8'h02 && ($urandom % 4) != 0) v = 8'h01;
          wr(1, v);
        end
        5, 6, 7: rd(1, "R5 random data read");
        8: rd(0, "R4 random index read");
        default: if (!m_open) begin
          if ($urandom % 2) wr(0, 8'h87);
          unlock4e();
        end
      endcase
      if (!m_open && ($urandom % 3) == 0) unlock4e();
      chk("R2 random lock state", {7'd0, unlocked}, {7'd0, m_open});
    end

    finish_run();
  end
endmodule